// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a compare-match timer. It counts edges of a slow reference clock that arrives asynchronously on a single pin. A divider sits between that clock and a 32-bit up-counter. Whenever the counter meets a programmable 32-bit compare value, the channel raises a match flag. If the counter rolls over from all ones to zero without a match, it raises a separate overflow flag.

The control word is 16 bits wide. The counter and compare registers are 32 bits wide. A two-bit routing field sends a pending match to a DMA request line, to an interrupt request line, or to neither. Counting is gated by this channel's bit in a start register. That register is shared with the other channels, but only this channel's bit is implemented here.

A value written to the counter does not land at once. It is held, and a write-pending status bit reads as one, until the second slow-clock rising edge after the write. On that edge the value is loaded. Until the load, a counter read returns the old count. System software uses the block as a periodic tick source (match clears the counter) or as a free-running time base (match only flags).

Top module: `cmt_channel_timer`

## Requirements
- R1: After reset, the control word reads 0x0000, the counter reads 0, the compare register reads 0xFFFFFFFF, the start register reads 0, and both request outputs are low.
- R2: The start register is at byte address 0x00, and this channel's start bit is bit CHAN_IDX (bit 0 by default). All other bits read as 0. The counter does not advance while this bit is 0. The channel's control, counter and compare registers are at 0x10+0x10*CHAN_IDX plus 0, 4 and 8.
- R3: Control bits 2:0 select the count rate. Code 4 counts once per 8 slow edges, 5 once per 32, 6 once per 128 and 7 on every slow edge. Codes 0 to 3 stop counting. Any control write restarts the divider phase.
- R4: After a counter write, reads return the previous count and control bit 13 reads 1 until the second slow rising edge after the write. On that edge the written value is loaded, replacing any increment due on that edge, and bit 13 returns to 0. Control bit 13 ignores writes.
- R5: With control bit 8 set (periodic), a count event with counter equal to compare sets control bit 15 and loads the counter with 0.
- R6: With control bit 8 clear (free-running), a match sets control bit 15 and the counter keeps incrementing.
- R7: A count event at 0xFFFFFFFF that is not a periodic match wraps the counter to 0 and sets control bit 14. In periodic mode with compare 0xFFFFFFFF, the counter returns to 0 with bit 15 set and bit 14 left clear.
- R8: Writing 0 to control bit 15 or bit 14 clears that flag. Writing 1 leaves it unchanged and never sets it. A hardware set in the same cycle wins.
- R9: Control bits 5:4 route the match flag. Code 1 drives dma_req high and code 2 drives irq_req high, each for as long as bit 15 is set. Codes 0 and 3 drive neither. The outputs are registered, one cycle behind the flag.
- R10: Control bits 12, 11, 10, 9, 7 and 3 are plain read/write storage. Bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_in | input | 1 | Asynchronous slow reference clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid the next cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| dma_req | output | 1 | Match request routed to DMA |
| irq_req | output | 1 | Match request routed to interrupt |

## Verification
The bench generates every slow edge itself, so the expected count is exact. It targets the counter-write window: a design that loads on the first edge, or lets the increment win over the load, reads back off by one or shows the new value early. It drives the counter across all ones with and without a matching compare: a wrong design flags overflow on a periodic match at 0xFFFFFFFF, or misses the wrap in free-running mode. It uses random divider codes and edge counts, which catch a swapped code-to-ratio mapping. It also writes ones to the flags and switches the routing, which shows any flag that write-one can set and any request sent to the wrong line.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int CTRL_W = 16;
  localparam int DIV_W  = 7;

  // control word bit positions
  localparam int B_MATCH   = 15;
  localparam int B_OVF     = 14;
  localparam int B_PEND    = 13;
  localparam int B_PERIOD  = 8;

  localparam logic [CTRL_W-1:0] STORE_MASK = 16'h1FBF;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_DMA  = 2'd1,
    ROUTE_IRQ  = 2'd2,
    ROUTE_RSVD = 2'd3
  } route_e;

  function automatic logic [DIV_W-1:0] div_limit(input logic [2:0] sel);
    case (sel)
      3'd4:    div_limit = DIV_W'(7);
      3'd5:    div_limit = DIV_W'(31);
      3'd6:    div_limit = DIV_W'(127);
      default: div_limit = '0;
    endcase
  endfunction

endpackage

// File: rtl/cmt_edge_sync.sv
module cmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_tick,
  input  logic       run,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       count_tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;
  logic             sel_ok;

  assign limit  = div_limit(sel);
  assign sel_ok = sel[2];

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      div_q <= '0;
    end else if (slow_tick && sel_ok) begin
      div_q <= (div_q == limit) ? '0 : div_q + 1'b1;
    end
  end

  assign count_tick = slow_tick && run && sel_ok && (div_q == limit);

  // R3: the phase counter never runs past the selected ratio
  assert_div_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (run && sel_ok && $stable(sel)) |=> (div_q <= limit));
endmodule

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
  parameter int W          = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slow_tick,
  input  logic         count_tick,
  input  logic         periodic,
  input  logic [W-1:0] cmp_val,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  input  logic         clr_match,
  input  logic         clr_ovf,
  output logic [W-1:0] cnt_q,
  output logic         pending_q,
  output logic         match_q,
  output logic         ovf_q
);
  localparam int AGE_W = $clog2(SYNC_TICKS + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(SYNC_TICKS - 1);

  logic [W-1:0]     pend_val_q;
  logic [AGE_W-1:0] age_q;
  logic             apply;
  logic             hit;
  logic             set_match;
  logic             set_ovf;

  assign apply     = pending_q && slow_tick && (age_q == AGE_LAST) && !wr_cnt;
  assign hit       = (cnt_q == cmp_val);
  assign set_match = count_tick && !apply && hit;
  assign set_ovf   = count_tick && !apply && (&cnt_q) && !(hit && periodic);

  // pending load bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_val_q <= '0;
      pending_q  <= 1'b0;
      age_q      <= '0;
    end else if (wr_cnt) begin
      pend_val_q <= wr_val;
      pending_q  <= 1'b1;
      age_q      <= '0;
    end else if (pending_q && slow_tick) begin
      if (age_q == AGE_LAST) begin
        pending_q <= 1'b0;
        age_q     <= '0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  // counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (apply) begin
      cnt_q <= pend_val_q;
    end else if (count_tick) begin
      if (hit && periodic) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  // flags: hardware set wins over software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      match_q <= set_match | (match_q & ~clr_match);
      ovf_q   <= set_ovf   | (ovf_q   & ~clr_ovf);
    end
  end

  assert_load_on_last_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (pending_q && slow_tick && age_q == AGE_LAST && !wr_cnt)
      |=> (cnt_q == $past(pend_val_q)) && !pending_q);

  assert_periodic_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (count_tick && !apply && hit && periodic) |=> (cnt_q == '0) && match_q);

  assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    (count_tick && !apply && (&cnt_q) && !(hit && periodic))
      |=> ovf_q && (cnt_q == '0));
endmodule

// File: rtl/cmt_channel_timer.sv
module cmt_channel_timer
  import cmt_pkg::*;
#(
  parameter int CHAN_IDX   = 0,
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dma_req,
  output logic              irq_req
);
  localparam int CH_BASE  = 16 + 16 * CHAN_IDX;
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(CH_BASE + 4);
  localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(CH_BASE + 8);

  logic              run_q;
  logic [CTRL_W-1:0] store_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              wr_ctrl, wr_cnt, wr_cmp, wr_start;
  logic              slow_tick, count_tick;
  logic [CNT_W-1:0]  cnt_val;
  logic              pending, match_flag, ovf_flag;
  logic [CTRL_W-1:0] ctrl_rd;
  route_e            route;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt   = bus_wr && (bus_addr == A_CNT);
  assign wr_cmp   = bus_wr && (bus_addr == A_CMP);
  assign wr_start = bus_wr && (bus_addr == A_START);
  assign route    = route_e'(store_q[5:4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      store_q <= '0;
      cmp_q   <= '1;
    end else begin
      if (wr_start) run_q   <= bus_wdata[CHAN_IDX];
      if (wr_ctrl)  store_q <= bus_wdata[CTRL_W-1:0] & STORE_MASK;
      if (wr_cmp)   cmp_q   <= bus_wdata[CNT_W-1:0];
    end
  end

  cmt_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(slow_clk_in), .rise_o(slow_tick)
  );

  cmt_prescaler u_div (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .run(run_q),
    .clr(wr_ctrl), .sel(store_q[2:0]), .count_tick(count_tick)
  );

  cmt_count_core #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS)) u_core (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .count_tick(count_tick),
    .periodic(store_q[B_PERIOD]), .cmp_val(cmp_q),
    .wr_cnt(wr_cnt), .wr_val(bus_wdata[CNT_W-1:0]),
    .clr_match(wr_ctrl && !bus_wdata[B_MATCH]),
    .clr_ovf(wr_ctrl && !bus_wdata[B_OVF]),
    .cnt_q(cnt_val), .pending_q(pending), .match_q(match_flag), .ovf_q(ovf_flag)
  );

  always_comb begin
    ctrl_rd          = store_q;
    ctrl_rd[B_MATCH] = match_flag;
    ctrl_rd[B_OVF]   = ovf_flag;
    ctrl_rd[B_PEND]  = pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_START: bus_rdata <= DATA_W'(run_q) << CHAN_IDX;
        A_CTRL:  bus_rdata <= DATA_W'(ctrl_rd);
        A_CNT:   bus_rdata <= DATA_W'(cnt_val);
        A_CMP:   bus_rdata <= DATA_W'(cmp_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      dma_req <= match_flag && (route == ROUTE_DMA);
      irq_req <= match_flag && (route == ROUTE_IRQ);
    end
  end

  assert_flag_clear_by_write_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(match_flag) |-> $past(wr_ctrl && !bus_wdata[B_MATCH]));

  assert_irq_route_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(match_flag && route == ROUTE_IRQ));

  assert_dma_route_R9: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(match_flag && route == ROUTE_DMA));
endmodule

// File: tb/cmt_channel_timer_test.sv
module cmt_channel_timer_test;
  localparam logic [7:0] A_START = 8'h00;
  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_CNT   = 8'h14;
  localparam logic [7:0] A_CMP   = 8'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_clk_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dma_req, irq_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmt_channel_timer uut (
    .clk(clk), .rst(rst), .slow_clk_in(slow_clk_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      slow_clk_in = 1'b1; repeat (4) @(negedge clk);
      slow_clk_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  // load the counter with the channel stopped: two slow edges complete it
  task automatic load_cnt(input logic [31:0] v);
    wr(A_CNT, v);
    pulses(2);
  endtask

  function automatic int ratio(input int sel);
    case (sel)
      4: return 8;
      5: return 32;
      6: return 128;
      default: return 1;
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
    rd(A_CNT, d);   chk("R1 count", d, 32'h0);
    rd(A_CMP, d);   chk("R1 compare", d, 32'hFFFF_FFFF);
    rd(A_START, d); chk("R1 start", d, 32'h0);
    chk("R1 requests", {30'd0, dma_req, irq_req}, 32'h0);

    // R2 start register: only bit 0 kept
    wr(A_START, 32'hFFFF_FFFF);
    rd(A_START, d); chk("R2 start readback", d, 32'h1);
    wr(A_START, 32'h0);

    // R4 load while stopped
    wr(A_CNT, 32'd100);
    rd(A_CNT, d);  chk("R4 old value before edges", d, 32'd0);
    rd(A_CTRL, d); chk("R4 pending set", {31'd0, d[13]}, 32'd1);
    pulses(1);
    rd(A_CNT, d);  chk("R4 old value after one edge", d, 32'd0);
    pulses(1);
    rd(A_CNT, d);  chk("R4 loaded after two edges", d, 32'd100);
    rd(A_CTRL, d); chk("R4 pending clear", {31'd0, d[13]}, 32'd0);

    // R2 stopped channel holds its count
    wr(A_CTRL, 32'h0007);
    pulses(5);
    rd(A_CNT, d); chk("R2 stopped holds", d, 32'd100);

    // R3 codes below 4 do not count
    wr(A_CTRL, 32'h0002);
    wr(A_START, 32'h1);
    pulses(5);
    wr(A_START, 32'h0);
    rd(A_CNT, d); chk("R3 code 2 idle", d, 32'd100);

    // R3 random divider codes and edge counts
    for (int it = 0; it < 5; it++) begin
      int sel = 4 + int'($urandom % 4);
      int n   = int'($urandom % 300);
      load_cnt(32'd0);
      wr(A_CTRL, 32'(sel));
      wr(A_START, 32'h1);
      pulses(n);
      wr(A_START, 32'h0);
      rd(A_CNT, d);
      chk($sformatf("R3 sel %0d edges %0d", sel, n), d, 32'(n / ratio(sel)));
    end

    // R4 load while running: load replaces increment
    wr(A_CMP, 32'hFFFF_0000);
    wr(A_CTRL, 32'h0007);
    load_cnt(32'd0);
    wr(A_START, 32'h1);
    wr(A_CNT, 32'd500);
    pulses(1);
    rd(A_CNT, d);  chk("R4 running old value", d, 32'd1);
    rd(A_CTRL, d); chk("R4 running pending", {31'd0, d[13]}, 32'd1);
    pulses(1);
    rd(A_CNT, d);  chk("R4 running load", d, 32'd500);
    pulses(1);
    rd(A_CNT, d);  chk("R4 counts on after load", d, 32'd501);
    wr(A_START, 32'h0);

    // R5 periodic match
    wr(A_CTRL, 32'h0107);
    wr(A_CMP, 32'd5);
    load_cnt(32'd0);
    wr(A_START, 32'h1);
    pulses(6);
    wr(A_START, 32'h0);
    rd(A_CNT, d);  chk("R5 periodic restart", d, 32'd0);
    rd(A_CTRL, d); chk("R5 match flag", d & 32'hC000, 32'h8000);

    // R9 routing with flag held (write 1 keeps it)
    wr(A_CTRL, 32'h8127);
    repeat (2) @(negedge clk);
    chk("R9 irq route", {30'd0, dma_req, irq_req}, 32'h1);
    wr(A_CTRL, 32'h8117);
    repeat (2) @(negedge clk);
    chk("R9 dma route", {30'd0, dma_req, irq_req}, 32'h2);
    wr(A_CTRL, 32'h8137);
    repeat (2) @(negedge clk);
    chk("R9 reserved route", {30'd0, dma_req, irq_req}, 32'h0);
    wr(A_CTRL, 32'h8107);
    repeat (2) @(negedge clk);
    chk("R9 none route", {30'd0, dma_req, irq_req}, 32'h0);

    // R8 clear by zero, one does not set
    wr(A_CTRL, 32'h0127);
    repeat (2) @(negedge clk);
    rd(A_CTRL, d); chk("R8 cleared", d & 32'hC000, 32'h0);
    chk("R8 request drops", {30'd0, dma_req, irq_req}, 32'h0);
    wr(A_CTRL, 32'hC107);
    rd(A_CTRL, d); chk("R8 write one no set", d & 32'hC000, 32'h0);

    // R6 free-running match
    wr(A_CTRL, 32'h0007);
    wr(A_CMP, 32'd3);
    load_cnt(32'd0);
    wr(A_START, 32'h1);
    pulses(5);
    wr(A_START, 32'h0);
    rd(A_CNT, d);  chk("R6 keeps counting", d, 32'd5);
    rd(A_CTRL, d); chk("R6 match flag", d & 32'hC000, 32'h8000);

    // R7 wrap without match
    wr(A_CTRL, 32'h0007);
    wr(A_CMP, 32'd10);
    load_cnt(32'hFFFF_FFFD);
    wr(A_START, 32'h1);
    pulses(3);
    wr(A_START, 32'h0);
    rd(A_CNT, d);  chk("R7 wrapped", d, 32'd0);
    rd(A_CTRL, d); chk("R7 overflow only", d & 32'hC000, 32'h4000);

    // R7 periodic compare all ones: match, no overflow
    wr(A_CTRL, 32'h0107);
    wr(A_CMP, 32'hFFFF_FFFF);
    load_cnt(32'hFFFF_FFFE);
    wr(A_START, 32'h1);
    pulses(2);
    wr(A_START, 32'h0);
    rd(A_CNT, d);  chk("R7 all-ones compare restart", d, 32'd0);
    rd(A_CTRL, d); chk("R7 match without overflow", d & 32'hC000, 32'h8000);

    // R10 storage bits, bit 13 read-only
    wr(A_CTRL, 32'h3EC8);
    rd(A_CTRL, d); chk("R10 storage bits", d, 32'h1E88);

    finish_run();
  end
endmodule